// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block folds a set of level-sensitive peripheral interrupt lines and a handful of bus-error event inputs into a single interrupt output. The first stage captures every incoming event into a status register that only software can clear. A global enable bit and a mask reduce that register to one summary bit.

The summary bit is the live input of a second stage. The second stage keeps a sticky status latch behind its own mask and drives the output pin. Because that latch is sticky, the output stays asserted after the first-stage condition goes away, until software clears it.

A 32-bit register port gives read and write access to both stages. It also holds a polarity register and a set of routing registers, which are stored but have no effect on the logic.

Top module: `irq_aggregator`

## Requirements
- R1: While peripheral line n (0..NUM_LINES-1) is high at a rising clock edge, bit (31-n) of the first-stage status register (offset 0x08) reads 1 from that edge on. A low level never clears the bit.
- R2: Error input e for e = 0..7 sets first-stage status bit e. Error input 8 sets status bit 10. All of these bits are sticky in the same way as R1.
- R3: A write to the first-stage status register (0x08) clears every bit written as 1 and leaves the other bits alone. If a source sets a bit in the same cycle that a write clears it, the bit stays 1.
- R4: The first-stage summary is 1 exactly when control bit 31 (offset 0x00) is 1 and the first-stage status AND the first-stage mask (offset 0x04) is nonzero. The summary is visible as bit 11 of the second-stage input register (offset 0x10). All other bits of that register read 0.
- R5: The second-stage input register is read-only, and writes to offset 0x10 change nothing.
- R6: On every clock edge the second-stage status (offset 0x18) is ORed with (input AND second-stage mask at offset 0x14), so its bits stay set after the input drops. A write to 0x18 clears the bits written as 1, and a bit whose set term is active in that same cycle stays 1.
- R7: irq_o is 1 exactly when the second-stage status is nonzero. It changes on the same clock edge as that status.
- R8: The polarity register (0x1C) and the routing registers (0x20 and 0x24) read back what was written and have no influence on irq_o.
- R9: The control register stores only bit 31 (enable), bit 30 (quiet mode) and bits 25:24 (start-frame width: 0 = 4 clocks, 1 = 6, 2 = 8). All its other bits read 0, and only bit 31 affects the logic.
- R10: A read of any offset not listed above returns 0xFFFFFFFF, and a write to one changes no register.
- R11: reg_rdata_o holds the value of the addressed register one clock edge after reg_rd_i is sampled high. Reads have no side effects.
- R12: After a synchronous reset, every register reads 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_irq_i | input | NUM_LINES | Level-high peripheral interrupt lines |
| bus_err_i | input | NUM_ERR | Bus-error and request event inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Aggregated interrupt output |

## Verification
In both stages, a software write-one-to-clear can land in the same cycle as a hardware set of the same bit. In the first stage, the bench drives a one-cycle peripheral pulse in exactly the cycle of the clearing write. In the second stage, it keeps the summary live while clearing the sticky latch. In both cases the bit must read back as 1, and irq_o must stay high. A clear issued once the source is gone must then take the bit and the output to 0.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int WORD_W     = 32;
  localparam int ERR_COUNT  = 9;

  // register byte offsets
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_MASK1  = 'h04;
  localparam int OFS_STAT1  = 'h08;
  localparam int OFS_IN2    = 'h10;
  localparam int OFS_MASK2  = 'h14;
  localparam int OFS_STAT2  = 'h18;
  localparam int OFS_POL2   = 'h1C;
  localparam int OFS_ROUTE0 = 'h20;

  // control register fields
  localparam int CTRL_EN_BIT = 31;
  localparam logic [WORD_W-1:0] CTRL_KEEP = 32'hC300_0000;

  // position of the first-stage summary in the second-stage input
  localparam int SUMMARY_BIT = 11;

  // status bit fed by error input e
  function automatic int err_bit(input int e);
    return (e == ERR_COUNT - 1) ? 10 : e;
  endfunction

endpackage

// File: rtl/irq_stage1_latch.sv
module irq_stage1_latch
  import irq_agg_pkg::*;
#(
  parameter int DW        = 32,
  parameter int NUM_LINES = 17,
  parameter int NUM_ERR   = ERR_COUNT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_ERR-1:0]   err_i,
  input  logic                 enable_i,
  input  logic [DW-1:0]        mask_i,
  input  logic                 clr_en_i,
  input  logic [DW-1:0]        clr_data_i,
  output logic [DW-1:0]        status_o,
  output logic                 summary_o
);

  logic [DW-1:0] status_q;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;

  always_comb begin
    set_vec = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      set_vec[DW-1-n] = line_i[n];
    end
    for (int e = 0; e < NUM_ERR; e++) begin
      set_vec[err_bit(e)] = set_vec[err_bit(e)] | err_i[e];
    end
  end

  assign clr_vec = clr_en_i ? clr_data_i : '0;

  // set takes priority over a same-cycle software clear
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_vec) | set_vec;
  end

  assign status_o  = status_q;
  assign summary_o = enable_i && ((status_q & mask_i) != '0);

  generate
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_chk
      assert_line_latch_R1: assert property (@(posedge clk) disable iff (rst)
        line_i[n] |=> status_q[DW-1-n])
        else $error("line %0d not latched", n);
    end
    for (genvar e = 0; e < NUM_ERR; e++) begin : g_err_chk
      assert_err_map_R2: assert property (@(posedge clk) disable iff (rst)
        err_i[e] |=> status_q[err_bit(e)])
        else $error("error input %0d not latched", e);
    end
  endgenerate

  assert_no_self_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !clr_en_i |=> ((status_q & $past(status_q)) == $past(status_q)))
    else $error("status bit dropped without a clear");

endmodule

// File: rtl/irq_stage2_sticky.sv
module irq_stage2_sticky
  import irq_agg_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SUM_BIT = SUMMARY_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          summary_i,
  input  logic [DW-1:0] mask_i,
  input  logic          clr_en_i,
  input  logic [DW-1:0] clr_data_i,
  output logic [DW-1:0] input_o,
  output logic [DW-1:0] status_o,
  output logic          irq_o
);

  logic [DW-1:0] status_q;
  logic [DW-1:0] status_d;
  logic          irq_q;

  always_comb begin
    input_o          = '0;
    input_o[SUM_BIT] = summary_i;
  end

  always_comb begin
    status_d = status_q;
    if (clr_en_i) status_d = status_d & ~clr_data_i;
    status_d = status_d | (input_o & mask_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= (status_d != '0);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (rst)
    (summary_i && mask_i[SUM_BIT]) |=> status_q[SUM_BIT])
    else $error("live masked summary not latched");

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (status_q[SUM_BIT] && !clr_en_i) |=> status_q[SUM_BIT])
    else $error("sticky bit dropped without a clear");

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int DW        = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_ROUTE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     status1_i,
  input  logic [DW-1:0]     input2_i,
  input  logic [DW-1:0]     status2_i,
  output logic [DW-1:0]     rdata_o,
  output logic              enable_o,
  output logic [DW-1:0]     mask1_o,
  output logic [DW-1:0]     mask2_o,
  output logic              clr1_o,
  output logic              clr2_o
);

  localparam logic [DW-1:0] CTRL_MASK = DW'(CTRL_KEEP);

  logic [DW-1:0] ctrl_q, mask1_q, mask2_q, pol_q;
  logic [DW-1:0] route_q [NUM_ROUTE];
  logic [DW-1:0] rd_mux;
  logic          rd_hit;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      mask1_q <= '0;
      mask2_q <= '0;
      pol_q   <= '0;
    end else if (wr_i) begin
      if (at(addr_i, OFS_CTRL))  ctrl_q  <= wdata_i & CTRL_MASK;
      if (at(addr_i, OFS_MASK1)) mask1_q <= wdata_i;
      if (at(addr_i, OFS_MASK2)) mask2_q <= wdata_i;
      if (at(addr_i, OFS_POL2))  pol_q   <= wdata_i;
    end
  end

  generate
    for (genvar r = 0; r < NUM_ROUTE; r++) begin : g_route
      always_ff @(posedge clk) begin
        if (rst) route_q[r] <= '0;
        else if (wr_i && at(addr_i, OFS_ROUTE0 + 4 * r)) route_q[r] <= wdata_i;
      end
    end
  endgenerate

  assign clr1_o = wr_i && at(addr_i, OFS_STAT1);
  assign clr2_o = wr_i && at(addr_i, OFS_STAT2);

  always_comb begin
    rd_mux = '1;
    rd_hit = 1'b0;
    if (at(addr_i, OFS_CTRL))  begin rd_mux = ctrl_q;    rd_hit = 1'b1; end
    if (at(addr_i, OFS_MASK1)) begin rd_mux = mask1_q;   rd_hit = 1'b1; end
    if (at(addr_i, OFS_STAT1)) begin rd_mux = status1_i; rd_hit = 1'b1; end
    if (at(addr_i, OFS_IN2))   begin rd_mux = input2_i;  rd_hit = 1'b1; end
    if (at(addr_i, OFS_MASK2)) begin rd_mux = mask2_q;   rd_hit = 1'b1; end
    if (at(addr_i, OFS_STAT2)) begin rd_mux = status2_i; rd_hit = 1'b1; end
    if (at(addr_i, OFS_POL2))  begin rd_mux = pol_q;     rd_hit = 1'b1; end
    for (int r = 0; r < NUM_ROUTE; r++) begin
      if (at(addr_i, OFS_ROUTE0 + 4 * r)) begin
        rd_mux = route_q[r];
        rd_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign enable_o = ctrl_q[CTRL_EN_BIT];
  assign mask1_o  = mask1_q;
  assign mask2_o  = mask2_q;

  assert_unmapped_ones_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !rd_hit) |=> (rdata_o == '1))
    else $error("unmapped read did not return all ones");

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o))
    else $error("read data changed without a read");

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int DW        = WORD_W,
  parameter int ADDR_W    = 8,
  parameter int NUM_LINES = 17,
  parameter int NUM_ERR   = ERR_COUNT,
  parameter int NUM_ROUTE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] periph_irq_i,
  input  logic [NUM_ERR-1:0]   bus_err_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  output logic                 irq_o
);

  logic          enable;
  logic [DW-1:0] mask1, mask2, status1, status2, input2;
  logic          clr1, clr2, summary;

  irq_agg_regs #(.DW(DW), .ADDR_W(ADDR_W), .NUM_ROUTE(NUM_ROUTE)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .status1_i (status1),
    .input2_i  (input2),
    .status2_i (status2),
    .rdata_o   (reg_rdata_o),
    .enable_o  (enable),
    .mask1_o   (mask1),
    .mask2_o   (mask2),
    .clr1_o    (clr1),
    .clr2_o    (clr2)
  );

  irq_stage1_latch #(.DW(DW), .NUM_LINES(NUM_LINES), .NUM_ERR(NUM_ERR)) u_stage1 (
    .clk        (clk),
    .rst        (rst),
    .line_i     (periph_irq_i),
    .err_i      (bus_err_i),
    .enable_i   (enable),
    .mask_i     (mask1),
    .clr_en_i   (clr1),
    .clr_data_i (reg_wdata_i),
    .status_o   (status1),
    .summary_o  (summary)
  );

  irq_stage2_sticky #(.DW(DW), .SUM_BIT(SUMMARY_BIT)) u_stage2 (
    .clk        (clk),
    .rst        (rst),
    .summary_i  (summary),
    .mask_i     (mask2),
    .clr_en_i   (clr2),
    .clr_data_i (reg_wdata_i),
    .input_o    (input2),
    .status_o   (status2),
    .irq_o      (irq_o)
  );

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (status2 != '0))
    else $error("irq_o disagrees with second-stage status");

  assert_summary_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (input2 == '0))
    else $error("summary active while disabled");

endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NL = 17;
  localparam int NE = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] lines = '0;
  logic [NE-1:0] errs = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  irq_aggregator dut_i (
    .clk(clk), .rst(rst), .periph_irq_i(lines), .bus_err_i(errs),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
    rd = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd_reg(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_line(input int n);
    @(negedge clk); lines[n] = 1'b1;
    @(negedge clk); lines[n] = 1'b0;
  endtask

  task automatic pulse_err(input logic [NE-1:0] v);
    @(negedge clk); errs = v;
    @(negedge clk); errs = '0;
  endtask

  task automatic t_reset;
    expect_reg("R12 ctrl", 8'h00, 0);
    expect_reg("R12 mask1", 8'h04, 0);
    expect_reg("R12 stat1", 8'h08, 0);
    expect_reg("R12 stat2", 8'h18, 0);
    expect_reg("R12 pol", 8'h1C, 0);
    chk("R12 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_line_latch;
    pulse_line(3);
    idle(1);
    expect_reg("R1 line3", 8'h08, 32'h1000_0000);
    expect_reg("R11 reread", 8'h08, 32'h1000_0000);
    pulse_line(16);
    idle(1);
    expect_reg("R1 line16", 8'h08, 32'h1000_8000);
    chk("R1 irq idle", {31'd0, irq}, 0);
    wr_reg(8'h08, 32'hFFFF_FFFF);
    expect_reg("R3 clear all", 8'h08, 0);
  endtask

  task automatic t_err_map;
    pulse_err(9'h100);
    idle(1);
    expect_reg("R2 err8", 8'h08, 32'h0000_0400);
    pulse_err(9'h0FF);
    idle(1);
    expect_reg("R2 all errs", 8'h08, 32'h0000_04FF);
    wr_reg(8'h08, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c_race;
    pulse_line(0);
    pulse_line(1);
    idle(1);
    wr_reg(8'h08, 32'h4000_0000);
    expect_reg("R3 partial clear", 8'h08, 32'h8000_0000);
    // clear bit 31 in the very cycle line 0 pulses
    @(negedge clk);
    wr = 1'b1; addr = 8'h08; wdata = 32'h8000_0000; lines[0] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; lines[0] = 1'b0;
    expect_reg("R3 set wins", 8'h08, 32'h8000_0000);
    wr_reg(8'h08, 32'hFFFF_FFFF);
    expect_reg("R3 cleared", 8'h08, 0);
  endtask

  task automatic t_summary;
    wr_reg(8'h00, 32'h8000_0000);
    wr_reg(8'h04, 32'h0000_0080);
    pulse_err(9'h080);
    idle(2);
    expect_reg("R4 summary on", 8'h10, 32'h0000_0800);
    chk("R7 unmasked stage2", {31'd0, irq}, 0);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    expect_reg("R5 input ro", 8'h10, 32'h0000_0800);
    wr_reg(8'h00, 32'h0);
    expect_reg("R4 disabled", 8'h10, 0);
    wr_reg(8'h00, 32'h8000_0000);
    wr_reg(8'h04, 32'h0000_0001);
    expect_reg("R4 masked off", 8'h10, 0);
    wr_reg(8'h04, 32'h0000_0080);
  endtask

  task automatic t_sticky;
    wr_reg(8'h14, 32'h0000_0800);
    idle(2);
    chk("R7 irq on", {31'd0, irq}, 1);
    expect_reg("R6 stat2 set", 8'h18, 32'h0000_0800);
    wr_reg(8'h04, 32'h0);
    idle(2);
    expect_reg("R6 input gone", 8'h10, 0);
    expect_reg("R6 sticky", 8'h18, 32'h0000_0800);
    chk("R7 irq held", {31'd0, irq}, 1);
    wr_reg(8'h18, 32'h0000_0800);
    chk("R7 irq cleared", {31'd0, irq}, 0);
    expect_reg("R6 stat2 clear", 8'h18, 0);
    // clear while the summary is still live
    wr_reg(8'h04, 32'h0000_0080);
    idle(2);
    wr_reg(8'h18, 32'hFFFF_FFFF);
    expect_reg("R6 set wins", 8'h18, 32'h0000_0800);
    chk("R7 irq stays", {31'd0, irq}, 1);
    wr_reg(8'h08, 32'hFFFF_FFFF);
    idle(1);
    wr_reg(8'h18, 32'hFFFF_FFFF);
    expect_reg("R6 final clear", 8'h18, 0);
    chk("R7 irq off", {31'd0, irq}, 0);
  endtask

  task automatic t_stored;
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    wr_reg(8'h20, 32'h1234_5678);
    wr_reg(8'h24, 32'h9ABC_DEF0);
    expect_reg("R8 pol", 8'h1C, 32'hFFFF_FFFF);
    expect_reg("R8 route0", 8'h20, 32'h1234_5678);
    expect_reg("R8 route1", 8'h24, 32'h9ABC_DEF0);
    idle(2);
    chk("R8 no irq", {31'd0, irq}, 0);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    expect_reg("R9 ctrl fields", 8'h00, 32'hC300_0000);
    wr_reg(8'h00, 32'h4100_0000);
    expect_reg("R9 ctrl quiet", 8'h00, 32'h4100_0000);
    pulse_err(9'h080);
    idle(2);
    expect_reg("R9 enable off", 8'h10, 0);
    wr_reg(8'h08, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped;
    wr_reg(8'h0C, 32'h0);
    wr_reg(8'h40, 32'h0);
    expect_reg("R10 read 0C", 8'h0C, 32'hFFFF_FFFF);
    expect_reg("R10 read 40", 8'h40, 32'hFFFF_FFFF);
    expect_reg("R10 read 01", 8'h01, 32'hFFFF_FFFF);
    expect_reg("R10 mask1 kept", 8'h04, 32'h0000_0080);
    expect_reg("R10 mask2 kept", 8'h14, 32'h0000_0800);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_line_latch();
    t_err_map();
    t_w1c_race();
    t_summary();
    t_sticky();
    t_stored();
    t_unmapped();
    finish_run();
  end

endmodule